// File: doc/BRIEF.md
# Receive Sampling-Point Tuning Search Engine

This block is a hardware sequencer that finds a good receive sampling delay for an eMMC link running in HS200 timing. It steps a 6-bit delay code upward from zero over a limited window of codes. For each code it loads the code into the delay line through an update handshake, then asks an external tester for one tuning-block transfer and receives a pass or fail verdict.

While it sweeps, the engine keeps track of the longest run of consecutive passing codes. When the sweep ends it loads the code at the middle of that run and reports it. If no code passed, it reports an error and loads nothing. A start request made outside HS200 timing does not run the search: it is answered at once with a flag telling the caller to use the generic tuning procedure.

Top module: `rx_sample_tuner`

## Requirements
- R1: After reset, busy, done, error, skipped, tune_load and test_req are all low and result is 0.
- R2: An accepted sweep loads codes 0, 1, ... SWEEP_LEN-1 in ascending order, each through its own tune_load pulse. tune_load and test_req are never high together. After a code's load is acknowledged, exactly one test request is issued, and test_req stays high until test_ack.
- R3: If tune_taken does not arrive within UPD_TIMEOUT cycles of tune_load rising, the load is withdrawn and that code counts as a failed step with no test request.
- R4: A failed step resets the current run length to zero. The best run is replaced only by a strictly longer run, so among equal runs the earliest one wins.
- R5: After the sweep, the chosen code is the last index of the best run minus floor(best length / 2). It is loaded through the same handshake and reported on result with error low.
- R6: If no step passed, done is raised with error high and result 0, and no final load is issued.
- R7: If the final load is not acknowledged within UPD_TIMEOUT cycles, done is raised with error high and result equal to the chosen code.
- R8: busy goes high in the cycle after an accepted start and stays high until the cycle in which done pulses for one cycle. busy is low while done is high.
- R9: A start pulse received while busy has no effect on the sweep, on the number of loads or tests, or on the result.
- R10: A start with hs200_mode low is not run. done and skipped pulse in the next cycle with error low, busy stays low, and no load is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (single-cycle pulse) |
| hs200_mode | input | 1 | High when the link is in HS200 timing |
| tune_code | output | 6 | Delay code presented to the delay line |
| tune_load | output | 1 | Update request. The delay line acknowledges it with tune_taken |
| tune_taken | input | 1 | Pulse: the presented code has taken effect |
| test_req | output | 1 | Request one tuning-block transfer |
| test_ack | input | 1 | Transfer finished. test_pass is valid |
| test_pass | input | 1 | Transfer verdict, 1 = pass |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | No passing code, or final load timed out. Valid with done and held |
| skipped | output | 1 | Pulses with done when the start came outside HS200 timing |
| result | output | 6 | Chosen code. Valid with done and held |

## Verification
A corrupted run length or end index does not show during the sweep. It appears only when the search finishes, as a wrong result or a wrong error flag. The final code is loaded one cycle after the last step is recorded, so a mismatch is visible within a few cycles of the last test acknowledgement. A fault in the code counter or the handshake shows earlier, as an out-of-order code on tune_code at some load or as a missing or extra test request. Both kinds of fault are caught by counting and comparing loads and tests against the pass pattern fed to each code.

// File: rtl/rx_tune_pkg.sv
package rx_tune_pkg;

    localparam int TUNE_W = 6;
    localparam int LEN_W  = TUNE_W + 1;

    typedef logic [TUNE_W-1:0] tune_code_t;
    typedef logic [LEN_W-1:0]  run_len_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_APPLY,
        ST_TEST,
        ST_STEP,
        ST_CALC,
        ST_FINAL
    } tune_state_e;

    // middle of a run given its last index and its length (half rounded down)
    function automatic tune_code_t centre_of(tune_code_t last_idx, run_len_t len);
        run_len_t half;
        half = len >> 1;
        return last_idx - half[TUNE_W-1:0];
    endfunction

endpackage

// File: rtl/tune_wait_timer.sv
module tune_wait_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = run && (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (!expired)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tune_streak_trk.sv
module tune_streak_trk
    import rx_tune_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       step,
    input  logic       pass,
    input  tune_code_t idx,
    output run_len_t   best_len,
    output tune_code_t best_end
);
    run_len_t cur_len;
    run_len_t cur_next;

    assign cur_next = cur_len + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_len  <= '0;
            best_len <= '0;
            best_end <= '0;
        end else if (step) begin
            if (pass) begin
                cur_len <= cur_next;
                if (cur_next > best_len) begin
                    best_len <= cur_next;
                    best_end <= idx;
                end
            end else begin
                cur_len <= '0;
            end
        end
    end
endmodule

// File: rtl/rx_sample_tuner.sv
module rx_sample_tuner
    import rx_tune_pkg::*;
#(
    parameter int SWEEP_LEN   = 40,
    parameter int UPD_TIMEOUT = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              hs200_mode,
    output logic [TUNE_W-1:0] tune_code,
    output logic              tune_load,
    input  logic              tune_taken,
    output logic              test_req,
    input  logic              test_ack,
    input  logic              test_pass,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic              skipped,
    output logic [TUNE_W-1:0] result
);
    localparam tune_code_t LAST_CODE = tune_code_t'(SWEEP_LEN - 1);

    tune_state_e state;
    tune_code_t  code_q;
    logic        pass_q;
    logic        timer_run;
    logic        timed_out;
    logic        sweep_go;
    run_len_t    best_len;
    tune_code_t  best_end;

    assign tune_code = code_q;
    assign tune_load = (state == ST_APPLY) || (state == ST_FINAL);
    assign test_req  = (state == ST_TEST);
    assign busy      = (state != ST_IDLE);
    assign timer_run = tune_load;
    assign sweep_go  = (state == ST_IDLE) && start && hs200_mode;

    tune_wait_timer #(.LIMIT(UPD_TIMEOUT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (timer_run),
        .expired (timed_out)
    );

    tune_streak_trk u_streak (
        .clk      (clk),
        .rst      (rst),
        .clr      (sweep_go),
        .step     (state == ST_STEP),
        .pass     (pass_q),
        .idx      (code_q),
        .best_len (best_len),
        .best_end (best_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            code_q  <= '0;
            pass_q  <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
            skipped <= 1'b0;
            result  <= '0;
        end else begin
            done    <= 1'b0;
            skipped <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (hs200_mode) begin
                            code_q <= '0;
                            state  <= ST_APPLY;
                        end else begin
                            done    <= 1'b1;
                            skipped <= 1'b1;
                            error   <= 1'b0;
                        end
                    end
                end
                ST_APPLY: begin
                    if (tune_taken) begin
                        state <= ST_TEST;
                    end else if (timed_out) begin
                        pass_q <= 1'b0;
                        state  <= ST_STEP;
                    end
                end
                ST_TEST: begin
                    if (test_ack) begin
                        pass_q <= test_pass;
                        state  <= ST_STEP;
                    end
                end
                ST_STEP: begin
                    if (code_q == LAST_CODE) begin
                        state <= ST_CALC;
                    end else begin
                        code_q <= code_q + 1'b1;
                        state  <= ST_APPLY;
                    end
                end
                ST_CALC: begin
                    if (best_len == '0) begin
                        done   <= 1'b1;
                        error  <= 1'b1;
                        result <= '0;
                        state  <= ST_IDLE;
                    end else begin
                        code_q <= centre_of(best_end, best_len);
                        state  <= ST_FINAL;
                    end
                end
                ST_FINAL: begin
                    if (tune_taken || timed_out) begin
                        done   <= 1'b1;
                        error  <= !tune_taken;
                        result <= code_q;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_sample_tuner_chk.sv
module rx_sample_tuner_chk #(
    parameter int SWEEP_LEN   = 40,
    parameter int UPD_TIMEOUT = 100
) (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic [5:0] tune_code,
    input logic       tune_load,
    input logic       tune_taken,
    input logic       test_req,
    input logic       test_ack,
    input logic       busy,
    input logic       done,
    input logic       error,
    input logic       skipped
);
    int load_run;

    always_ff @(posedge clk) begin
        if (rst || !tune_load)
            load_run <= 0;
        else
            load_run <= load_run + 1;
    end

    assert_load_window_R3: assert property (@(posedge clk) disable iff (rst)
        tune_load |-> load_run < UPD_TIMEOUT);

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(tune_load && test_req));

    assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
        test_req && !test_ack |=> test_req);

    assert_code_range_R2: assert property (@(posedge clk) disable iff (rst)
        test_req |-> int'(tune_code) < SWEEP_LEN);

    assert_code_stable_R3: assert property (@(posedge clk) disable iff (rst)
        tune_load && !tune_taken |=> !tune_load || $stable(tune_code));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> busy || done);

    assert_skip_clean_R10: assert property (@(posedge clk) disable iff (rst)
        skipped |-> done && !error && !busy);

endmodule

bind rx_sample_tuner rx_sample_tuner_chk #(
    .SWEEP_LEN   (SWEEP_LEN),
    .UPD_TIMEOUT (UPD_TIMEOUT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tune_code  (tune_code),
    .tune_load  (tune_load),
    .tune_taken (tune_taken),
    .test_req   (test_req),
    .test_ack   (test_ack),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .skipped    (skipped)
);

// File: tb/rx_sample_tuner_test.sv
module rx_sample_tuner_test;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP      = 40;
    localparam int TMO        = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       hs200_mode = 1'b1;
    logic [5:0] tune_code;
    logic       tune_load;
    logic       tune_taken = 1'b0;
    logic       test_req;
    logic       test_ack = 1'b0;
    logic       test_pass = 1'b0;
    logic       busy, done, error, skipped;
    logic [5:0] result;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_sample_tuner #(.SWEEP_LEN(SWEEP), .UPD_TIMEOUT(TMO)) uut (
        .clk(clk), .rst(rst), .start(start), .hs200_mode(hs200_mode),
        .tune_code(tune_code), .tune_load(tune_load), .tune_taken(tune_taken),
        .test_req(test_req), .test_ack(test_ack), .test_pass(test_pass),
        .busy(busy), .done(done), .error(error), .skipped(skipped),
        .result(result)
    );

    int vectors = 0;
    int miscompares = 0;

    logic [63:0] pat   = '0;
    logic [63:0] stall = '0;
    bit          fstall = 1'b0;
    int loads = 0, tests = 0, seq_err = 0, last_applied = -1;
    int phy_cnt = 0, tst_cnt = 0;
    bit prev_load = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // delay-line model: acknowledges a load on its third observed cycle unless stalled
    initial begin
        forever begin
            @(negedge clk);
            tune_taken = 1'b0;
            if (tune_load) begin
                if (!prev_load) begin
                    if (loads < SWEEP && int'(tune_code) != loads) seq_err++;
                    loads++;
                    phy_cnt = 0;
                end else begin
                    phy_cnt++;
                end
                if (phy_cnt == 2) begin
                    if (!((loads <= SWEEP) ? stall[loads-1] : fstall)) begin
                        tune_taken = 1'b1;
                        last_applied = int'(tune_code);
                    end
                end
            end
            prev_load = tune_load;
        end
    end

    // tester model: answers a request on its second observed cycle
    initial begin
        forever begin
            @(negedge clk);
            test_ack = 1'b0;
            if (test_req) begin
                if (tst_cnt == 1) begin
                    test_ack  = 1'b1;
                    test_pass = pat[tune_code];
                    tests++;
                    tst_cnt = 0;
                end else begin
                    tst_cnt++;
                end
            end else begin
                tst_cnt = 0;
            end
        end
    end

    task automatic run_case(input string name, input logic [63:0] p, input logic [63:0] s,
                            input bit fs, input bit mid);
        int cur, best, last, exp_tests, exp_loads, exp_res, n, busy_bad;
        bit exp_err;
        cur = 0; best = 0; last = 0; exp_tests = 0;
        for (int i = 0; i < SWEEP; i++) begin
            if (!s[i]) exp_tests++;
            if (p[i] && !s[i]) begin
                cur++;
                if (cur > best) begin best = cur; last = i; end
            end else begin
                cur = 0;
            end
        end
        exp_loads = SWEEP + ((best > 0) ? 1 : 0);
        exp_res   = (best > 0) ? last - best / 2 : 0;
        exp_err   = (best == 0) || fs;

        pat = p; stall = s; fstall = fs;
        loads = 0; tests = 0; seq_err = 0; last_applied = -1;
        hs200_mode = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, {"R8 busy after start ", name}, busy, 1);
        n = 0; busy_bad = 0;
        while (!done && n < 5000) begin
            if (!busy) busy_bad++;
            start = (mid && n == 50);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk(n < 5000, {"R8 done reached ", name}, n, 0);
        chk(busy_bad == 0, {"R8 busy held ", name}, busy_bad, 0);
        chk(busy == 1'b0, {"R8 busy low at done ", name}, busy, 0);
        chk(error == exp_err, {"R4 R6 R7 error ", name}, error, exp_err);
        chk(int'(result) == exp_res, {"R4 R5 result ", name}, result, exp_res);
        chk(loads == exp_loads, {"R2 R6 R9 load count ", name}, loads, exp_loads);
        chk(tests == exp_tests, {"R3 R9 test count ", name}, tests, exp_tests);
        chk(seq_err == 0, {"R2 code order ", name}, seq_err, 0);
        if (!exp_err)
            chk(last_applied == exp_res, {"R5 final load ", name}, last_applied, exp_res);
        @(negedge clk);
        chk(done == 1'b0, {"R8 done pulse ", name}, done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] p;
        int sft;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && error == 0 && skipped == 0, "R1 status", busy, 0);
        chk(tune_load == 0 && test_req == 0, "R1 handshakes", tune_load, 0);
        chk(result == 0, "R1 result", result, 0);
        rst = 1'b0;
        @(negedge clk);

        run_case("all pass",      {24'd0, {40{1'b1}}}, '0, 0, 0);   // R5 centre 19
        run_case("all fail",      '0, '0, 0, 0);                     // R6
        run_case("only first",    64'h1, '0, 0, 0);
        run_case("only last",     64'h1 << 39, '0, 0, 0);
        run_case("tie earliest",  (64'h1F << 5) | (64'h1F << 20), '0, 0, 0);      // R4
        run_case("longer later",  (64'hF << 10) | (64'h3F << 30), '0, 0, 0);      // R4
        run_case("stall splits",  {24'd0, {40{1'b1}}}, 64'h1 << 20, 0, 0);        // R3
        run_case("all stall",     {24'd0, {40{1'b1}}}, {24'd0, {40{1'b1}}}, 0, 0); // R3 R6
        run_case("final stall",   64'h3F << 3, '0, 1, 0);                          // R7
        run_case("busy start",    (64'hF << 10) | (64'h3F << 30), '0, 0, 1);      // R9

        // R10 start outside HS200 timing
        loads = 0;
        hs200_mode = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1 && skipped == 1, "R10 skipped done", skipped, 1);
        chk(error == 0 && busy == 0, "R10 no error, idle", error, 0);
        repeat (5) @(negedge clk);
        chk(loads == 0 && skipped == 0, "R10 no load", loads, 0);
        hs200_mode = 1'b1;

        // R4 R5 single windows of every width
        for (int w = 1; w <= SWEEP; w++) begin
            sft = (w * 7) % (SWEEP + 1 - w);
            p = ((64'h1 << w) - 64'h1) << sft;
            run_case($sformatf("window w=%0d s=%0d", w, sft), p, '0, 0, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule